// File: doc/BRIEF.md
# Multi-function pad configuration controller

This block sits between a set of internal peripheral outputs and a single external pad. Eight alternate-function sources offer an output level, an output enable and a pull request. One 16-bit configuration word, written over a simple register bus, chooses which source reaches the pad. The same word sets the pull resistors and the drive-strength code for the pad cell. It also sets a pad state used while the chip sleeps, and arms rising and falling edge detection on the pad input.

The pad input passes through a two-flop synchronizer. An armed edge sets a sticky status flag. A flag becomes a wakeup request only while the external wakeup-enable input is high. The flag stays set until software clears it through the clear bit of the register.

Configuration word layout (bit positions matter to the pad cell and to software):
- [2:0] function select
- [4] arm rising edge
- [5] arm falling edge
- [6] clear and hold edge detection off
- [7] sleep output enable, active low
- [8] sleep output level
- [9] use the sleep state in low power
- [12:10] drive code
- [13] pull-down
- [14] pull-up
- [15] take the pull from the selected function

Top module: `padmux_cfg`

## Requirements
- R1: After reset the register reads 0. The pad follows function 0 (pad_out = af_out[0], pad_oe = af_oe[0]), and both pulls, drive_code, pad_slow, edge_flag and wake_req are 0.
- R2: Outside low power, or while bit 9 is 0, pad_out and pad_oe equal af_out[s] and af_oe[s], where s = bits [2:0]. The pad follows a register write from the first clock edge that stores it.
- R3: With bit 15 = 0, pad_pu = bit 14 and pad_pd = bit 13. With bit 15 = 1, pad_pu = af_pu[s] and pad_pd = af_pd[s].
- R4: drive_code equals bits [12:10]. pad_slow is 1 for codes 4 and 6 and is 0 for all other codes.
- R5: While lp_mode = 1 and bit 9 = 1, pad_out = bit 8 and pad_oe = NOT bit 7, whatever function is selected. Leaving low power returns the pad to the selected function at once.
- R6: With bit 4 set, a 0-to-1 change on pad_in sets edge_flag[0] at the third rising clock edge after the change, not before. With bit 5 set, a 1-to-0 change sets edge_flag[1] in the same way. A change whose arm bit is clear sets nothing. A set flag stays set.
- R7: Writing 1 to bit 6 clears both flags at the edge that stores the write. While bit 6 stays 1, no pad change sets a flag.
- R8: wake_req is 1 only while wake_en = 1 and at least one flag is set. It follows wake_en without a clock edge.
- R9: Bits [31:16] and bit 3 of reg_rdata always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register contents |
| af_out | input | 8 | Output level of each alternate function |
| af_oe | input | 8 | Output enable of each alternate function |
| af_pu | input | 8 | Pull-up request of each alternate function |
| af_pd | input | 8 | Pull-down request of each alternate function |
| lp_mode | input | 1 | Low-power mode active |
| wake_en | input | 1 | External wakeup enable |
| pad_in | input | 1 | Asynchronous pad input level |
| pad_out | output | 1 | Level driven to the pad |
| pad_oe | output | 1 | Pad output enable |
| pad_pu | output | 1 | Pull-up enable |
| pad_pd | output | 1 | Pull-down enable |
| drive_code | output | 3 | Drive strength and slew code to the pad cell |
| pad_slow | output | 1 | Slow-slew code selected |
| edge_flag | output | 2 | Sticky edge flags, [0] rising, [1] falling |
| wake_req | output | 1 | Wakeup request |

## Verification
The register, the pad mux, the pulls and the drive code follow a write from the clock edge that stores it. The bench therefore drives each write on a falling edge and checks these outputs on the next falling edge. lp_mode and wake_en act without a clock, so their checks run one time step after the input changes. An edge flag is due at the third rising edge after a pad change: two synchronizer flops, then the status flop. The bench checks that the flag is still clear after two edges and set after three. It checks that unarmed or cleared edges leave the flags at zero after four edges.

// File: rtl/padmux_cfg.sv
module padmux_cfg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [7:0]  af_out,
  input  logic [7:0]  af_oe,
  input  logic [7:0]  af_pu,
  input  logic [7:0]  af_pd,
  input  logic        lp_mode,
  input  logic        wake_en,
  input  logic        pad_in,
  output logic        pad_out,
  output logic        pad_oe,
  output logic        pad_pu,
  output logic        pad_pd,
  output logic [2:0]  drive_code,
  output logic        pad_slow,
  output logic [1:0]  edge_flag,
  output logic        wake_req
);
  localparam logic [15:0] WR_MASK = 16'hFFF7;
  localparam int B_RISE = 4, B_FALL = 5, B_CLR = 6, B_SOE_N = 7;
  localparam int B_SDAT = 8, B_SSEL = 9, B_PD = 13, B_PU = 14, B_PSEL = 15;

  logic [15:0] cfg;
  logic [2:0]  sel;
  logic        sync1, sync2, last;
  logic        clr_now, sleep_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg <= '0;
    else if (reg_wr) cfg <= reg_wdata[15:0] & WR_MASK;

  assign reg_rdata = {16'h0000, cfg};
  assign sel       = cfg[2:0];

  assign sleep_on = lp_mode && cfg[B_SSEL];
  assign pad_out  = sleep_on ? cfg[B_SDAT]    : af_out[sel];
  assign pad_oe   = sleep_on ? !cfg[B_SOE_N]  : af_oe[sel];
  assign pad_pu   = cfg[B_PSEL] ? af_pu[sel] : cfg[B_PU];
  assign pad_pd   = cfg[B_PSEL] ? af_pd[sel] : cfg[B_PD];

  assign drive_code = cfg[12:10];
  assign pad_slow   = (drive_code == 3'd4) || (drive_code == 3'd6);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sync1, sync2, last} <= '0;
    else {sync1, sync2, last} <= {pad_in, sync1, sync2};

  assign clr_now = cfg[B_CLR] || (reg_wr && reg_wdata[B_CLR]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) edge_flag <= '0;
    else if (clr_now) edge_flag <= '0;
    else begin
      if (cfg[B_RISE] && sync2 && !last) edge_flag[0] <= 1'b1;
      if (cfg[B_FALL] && !sync2 && last) edge_flag[1] <= 1'b1;
    end

  assign wake_req = wake_en && (|edge_flag);
endmodule

// File: rtl/padmux_cfg_chk.sv
module padmux_cfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        lp_mode,
  input logic        wake_en,
  input logic        pad_out,
  input logic        pad_oe,
  input logic [2:0]  drive_code,
  input logic [1:0]  edge_flag,
  input logic        wake_req
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:16] == 16'h0 && !reg_rdata[3]);                                  // R9
  AST_DRIVE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    drive_code == reg_rdata[12:10]);                                              // R4
  AST_SLEEP_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && reg_rdata[9]) |-> (pad_out == reg_rdata[8] && pad_oe == !reg_rdata[7])); // R5
  AST_RISE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_flag[0]) |-> $past(reg_rdata[4]));                                 // R6
  AST_FALL_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_flag[1]) |-> $past(reg_rdata[5]));                                 // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag[0] && !reg_rdata[6] && !(reg_wr && reg_wdata[6])) |=> edge_flag[0]); // R6
  AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6] |=> edge_flag == 2'b00);                                         // R7
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (wake_en && edge_flag != 2'b00));                                // R8
endmodule

bind padmux_cfg padmux_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .lp_mode(lp_mode), .wake_en(wake_en),
  .pad_out(pad_out), .pad_oe(pad_oe), .drive_code(drive_code),
  .edge_flag(edge_flag), .wake_req(wake_req)
);

// File: tb/padmux_cfg_bench.sv
module padmux_cfg_bench;
  logic        clk = 0, rst_n = 0, reg_wr = 0, lp_mode = 0, wake_en = 0, pad_in = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0]  af_out = 8'b1010_0110, af_oe = 8'b1100_0011;
  logic [7:0]  af_pu = 8'b0000_1111, af_pd = 8'b1111_0000;
  logic        pad_out, pad_oe, pad_pu, pad_pd, pad_slow, wake_req;
  logic [2:0]  drive_code;
  logic [1:0]  edge_flag;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  padmux_cfg u_padmux_cfg (.*);

  // {cfg[15:0], lp, out, oe, pu, pd}
  localparam logic [20:0] VEC [13] = '{
    {16'h0000, 1'b0, 4'b0100}, {16'h0001, 1'b0, 4'b1100},
    {16'h0002, 1'b0, 4'b1000}, {16'h0007, 1'b0, 4'b1100},
    {16'h6005, 1'b0, 4'b1011}, {16'h8003, 1'b0, 4'b0010},
    {16'h8006, 1'b0, 4'b0101}, {16'h0300, 1'b1, 4'b1100},
    {16'h0380, 1'b1, 4'b1000}, {16'h0201, 1'b1, 4'b0100},
    {16'h0101, 1'b1, 4'b1100}, {16'h0300, 1'b0, 4'b0100},
    {16'h4300, 1'b1, 4'b1110}};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk); reg_wdata = v; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(2);
    rst_n = 1;
    cyc(1);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 pad", {pad_out, pad_oe, pad_pu, pad_pd}, 4'b0100);
    chk("R1 drive", {drive_code, pad_slow, edge_flag, wake_req}, 0);

    for (int i = 0; i < 13; i++) begin
      wr({16'h0, VEC[i][20:5]});
      lp_mode = VEC[i][4];
      #1;
      chk($sformatf("R2/R3/R5 vec%0d", i), {pad_out, pad_oe, pad_pu, pad_pd}, VEC[i][3:0]);
    end
    lp_mode = 1; wr(32'h0000_0380); #1;
    chk("R5 sleep oe off", {pad_out, pad_oe}, 2'b10);
    lp_mode = 0; #1;
    chk("R5 leave low power", {pad_out, pad_oe}, 2'b01);

    for (int d = 0; d < 8; d++) begin
      wr(32'(d) << 10);
      chk($sformatf("R4 code%0d", d), {drive_code, pad_slow}, {3'(d), (d == 4 || d == 6)});
    end

    wr(32'hFFFF_FFFF);
    chk("R9 reserved", reg_rdata, 32'h0000_FFF7);

    wr(32'h0000_0010);
    chk("R7 prior clear", edge_flag, 0);
    @(negedge clk); pad_in = 1;
    cyc(2);
    chk("R6 rise not early", edge_flag, 0);
    cyc(1);
    chk("R6 rise latched", edge_flag, 2'b01);
    pad_in = 0; cyc(4);
    chk("R6 fall unarmed, rise sticky", edge_flag, 2'b01);
    chk("R8 wake gated off", wake_req, 0);
    wake_en = 1; #1;
    chk("R8 wake on", wake_req, 1);

    wr(32'h0000_0070);
    chk("R7 clear", {edge_flag, wake_req}, 0);
    pad_in = 1; cyc(4); pad_in = 0; cyc(4);
    chk("R7 held off", edge_flag, 0);

    wr(32'h0000_0030);
    pad_in = 1; cyc(3);
    chk("R6 rise both armed", edge_flag, 2'b01);
    pad_in = 0; cyc(2);
    chk("R6 fall not early", edge_flag, 2'b01);
    cyc(1);
    chk("R6 fall latched", edge_flag, 2'b11);
    chk("R8 wake both", wake_req, 1);
    wake_en = 0; #1;
    chk("R8 wake dropped", wake_req, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule